// File: doc/BRIEF.md
# Select-Coded Arithmetic Logic Unit

This is a combinational ALU with a parameterised operand width (8 bits by default). It combines two operands under a 4-bit select word and returns a result and four status flags. In arithmetic mode, every operation runs through one shared adder, A + Y + cin. The operand Y is formed from B by a small shaping stage that outputs zero, B, the complement of B, or all ones. In logic mode, a bitwise unit produces the result in place of the adder.

A controller drives the select word and the operands in the same cycle and samples the result and flags combinationally. The flags are overflow, carry, negative and zero. A controller can branch on them or store them.

Top module: `sel_alu`

## Requirements
- R1: `gsel_i[3]` is the mode bit. When it is 0 (arithmetic), `g_o` = (A + Y + cin) mod 2^WIDTH, where cin is `gsel_i[0]`.
- R2: In arithmetic mode, `gsel_i[2:1]` chooses Y. The codes are 00 for zero, 01 for B, 10 for the complement of B, and 11 for all ones. As a result, select 0000 passes A, 0001 gives A+1, 0010 gives A+B, 0011 gives A+B+1, 0101 gives A−B, and 0110 gives A−1.
- R3: When `gsel_i[3]` is 1 (logic), `gsel_i[2:1]` chooses the operation. The codes are 00 for AND, 01 for OR, 10 for XOR and 11 for NOT A. `gsel_i[0]` has no effect on any output in this mode.
- R4: In arithmetic mode, `c_o` is the carry out of the top bit. `v_o` is the XOR of the carries into and out of the top bit, which is two's-complement overflow of A + Y + cin.
- R5: In logic mode, `c_o` and `v_o` are both 0.
- R6: `n_o` equals the top bit of `g_o` in both modes.
- R7: `z_o` is 1 exactly when every bit of `g_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| gsel_i | input | 4 | Select word: mode, two op bits, carry-in (MSB to LSB) |
| g_o | output | WIDTH | Result |
| v_o | output | 1 | Signed overflow |
| c_o | output | 1 | Carry out |
| n_o | output | 1 | Negative (result MSB) |
| z_o | output | 1 | Zero result |

## Verification
A 4-bit instance is swept over all 16 select codes and every operand pair. This sweep distinguishes the four Y choices and the effect of the carry-in. It also covers each carry and overflow boundary, so a wrong carry tap or a swapped logic code shows up. An 8-bit instance is run with the operand values 0, 1, 0x7F, 0x80, 0xFE and 0xFF under every select code. These values hit the signed wrap points and the all-ones cases at the default width. Pairs of selects that differ only in the carry-in bit are compared in logic mode, which shows that the carry-in is ignored there.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;
   typedef enum logic [1:0] {
      Y_ZERO = 2'b00,
      Y_B    = 2'b01,
      Y_NOTB = 2'b10,
      Y_ONES = 2'b11
   } y_pick_e;

   typedef enum logic [1:0] {
      LG_AND = 2'b00,
      LG_OR  = 2'b01,
      LG_XOR = 2'b10,
      LG_NOT = 2'b11
   } lg_op_e;

   typedef struct packed {
      logic       mode_logic;
      logic [1:0] op;
      logic       cin;
   } gsel_t;
endpackage

// File: rtl/sel_alu_yshape.sv
module sel_alu_yshape #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       pick_i,
   output logic [WIDTH-1:0] y_o
);
   // Per-bit sum of products: keep B where pick[0], keep ~B where pick[1]
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign y_o[i] = (b_i[i] & pick_i[0]) | (~b_i[i] & pick_i[1]);
   end
endmodule

// File: rtl/sel_alu_adder.sv
module sel_alu_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             cmsb_o
);
   localparam int LOW = WIDTH - 1;

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_fa
         assign sum_o[i]  = a_i[i] ^ y_i[i] ^ cy[i];
         assign cy[i+1]   = (a_i[i] & y_i[i]) | (cy[i] & (a_i[i] ^ y_i[i]));
      end
      assign cout_o = cy[WIDTH];
      assign cmsb_o = cy[LOW];
   end else begin : g_infer
      logic [LOW:0]   low_sum;
      logic [WIDTH:0] full_sum;
      assign low_sum  = {1'b0, a_i[LOW-1:0]} + {1'b0, y_i[LOW-1:0]} + {{LOW{1'b0}}, cin_i};
      assign full_sum = {1'b0, a_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
      assign sum_o  = full_sum[WIDTH-1:0];
      assign cout_o = full_sum[WIDTH];
      assign cmsb_o = low_sum[LOW];
   end
endmodule

// File: rtl/sel_alu_logic.sv
module sel_alu_logic
   import sel_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  lg_op_e           op_i,
   output logic [WIDTH-1:0] r_o
);
   always_comb begin
      unique case (op_i)
         LG_AND:  r_o = a_i & b_i;
         LG_OR:   r_o = a_i | b_i;
         LG_XOR:  r_o = a_i ^ b_i;
         default: r_o = ~a_i;
      endcase
   end
endmodule

// File: rtl/sel_alu.sv
module sel_alu
   import sel_alu_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       gsel_i,
   output logic [WIDTH-1:0] g_o,
   output logic             v_o,
   output logic             c_o,
   output logic             n_o,
   output logic             z_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sel_alu: WIDTH must be at least 2");
   end

   gsel_t             sel;
   logic [WIDTH-1:0]  y;
   logic [WIDTH-1:0]  sum;
   logic [WIDTH-1:0]  lres;
   logic              cout;
   logic              cmsb;

   assign sel = gsel_t'(gsel_i);

   sel_alu_yshape #(.WIDTH(WIDTH)) u_yshape (
      .b_i    (b_i),
      .pick_i (sel.op),
      .y_o    (y)
   );

   sel_alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
      .a_i    (a_i),
      .y_i    (y),
      .cin_i  (sel.cin),
      .sum_o  (sum),
      .cout_o (cout),
      .cmsb_o (cmsb)
   );

   sel_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i  (a_i),
      .b_i  (b_i),
      .op_i (lg_op_e'(sel.op)),
      .r_o  (lres)
   );

   assign g_o = sel.mode_logic ? lres : sum;
   assign c_o = ~sel.mode_logic & cout;
   assign v_o = ~sel.mode_logic & (cout ^ cmsb);
   assign n_o = g_o[MSB];
   assign z_o = ~|g_o;

   always_comb begin
      if (!sel.mode_logic) begin
         // R4: overflow only when operands share a sign and the result's sign differs
         p_overflow_sign_r4: assert (v_o == ((a_i[MSB] == y[MSB]) && (g_o[MSB] != a_i[MSB])))
            else $error("overflow flag disagrees with operand signs");
         if (gsel_i[2:0] == 3'b000) begin
            p_pass_a_r2: assert (g_o == a_i) else $error("select 0000 did not pass A");
         end
      end else begin
         p_logic_flags_clear_r5: assert (!v_o && !c_o) else $error("arith flags set in logic mode");
      end
      p_neg_msb_r6: assert (n_o == g_o[MSB]) else $error("negative flag mismatch");
      p_zero_r7: assert (z_o != (|g_o)) else $error("zero flag mismatch");
   end
endmodule

// File: tb/tb_sel_alu.sv
module tb_sel_alu;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [3:0] a4, b4, s4;
   logic [3:0] g4;
   logic       v4, c4, n4, z4;
   logic [7:0] a8, b8;
   logic [3:0] s8;
   logic [7:0] g8;
   logic       v8, c8, n8, z8;

   sel_alu #(.WIDTH(4), .RIPPLE(1'b1)) dut (
      .a_i(a4), .b_i(b4), .gsel_i(s4),
      .g_o(g4), .v_o(v4), .c_o(c4), .n_o(n4), .z_o(z4));

   sel_alu #(.WIDTH(8), .RIPPLE(1'b0)) dut8 (
      .a_i(a8), .b_i(b8), .gsel_i(s8),
      .g_o(g8), .v_o(v8), .c_o(c8), .n_o(n8), .z_o(z8));

   // returns {g[15:0], v, c, n, z}
   function automatic logic [19:0] model(int w, int a, int b, int sel);
      int mask = (1 << w) - 1;
      int half = 1 << (w - 1);
      int cin  = sel & 1;
      int op   = (sel >> 1) & 3;
      int y, sum, g, sa, sy, ss;
      logic v, c;
      if ((sel & 8) == 0) begin
         case (op)
            0: y = 0;
            1: y = b;
            2: y = (~b) & mask;
            default: y = mask;
         endcase
         sum = a + y + cin;
         g   = sum & mask;
         c   = ((sum >> w) & 1) == 1;
         sa  = (a >= half) ? a - (1 << w) : a;
         sy  = (y >= half) ? y - (1 << w) : y;
         ss  = sa + sy + cin;
         v   = (ss > half - 1) || (ss < -half);
      end else begin
         case (op)
            0: g = a & b;
            1: g = a | b;
            2: g = a ^ b;
            default: g = (~a) & mask;
         endcase
         v = 1'b0;
         c = 1'b0;
      end
      return {g[15:0], v, c, (g & half) != 0, g == 0};
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run4(int a, int b, int s);
      logic [19:0] e;
      @(posedge clk);
      a4 = a[3:0]; b4 = b[3:0]; s4 = s[3:0];
      #2;
      e = model(4, a, b, s);
      chk(s[3] ? "R3" : "R1", "g4", int'(g4), int'(e[19:4]));
      chk(s[3] ? "R5" : "R4", "v4", int'(v4), int'(e[3]));
      chk(s[3] ? "R5" : "R4", "c4", int'(c4), int'(e[2]));
      chk("R6", "n4", int'(n4), int'(e[1]));
      chk("R7", "z4", int'(z4), int'(e[0]));
   endtask

   task automatic run8(int a, int b, int s);
      logic [19:0] e;
      @(posedge clk);
      a8 = a[7:0]; b8 = b[7:0]; s8 = s[3:0];
      #2;
      e = model(8, a, b, s);
      chk(s[3] ? "R3" : "R1", "g8", int'(g8), int'(e[19:4]));
      chk(s[3] ? "R5" : "R4", "v8", int'(v8), int'(e[3]));
      chk(s[3] ? "R5" : "R4", "c8", int'(c8), int'(e[2]));
      chk("R6", "n8", int'(n8), int'(e[1]));
      chk("R7", "z8", int'(z8), int'(e[0]));
   endtask

   initial begin
      int edges [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
      logic [7:0] gsave;
      a4 = '0; b4 = '0; s4 = '0; a8 = '0; b8 = '0; s8 = '0;
      // initial state: all-zero inputs give zero result with Z set
      @(posedge clk); #2;
      chk("R7", "initial z", int'(z4), 1);
      chk("R1", "initial g", int'(g4), 0);
      // R2 named cases at 8 bits: A=0x5A, B=0x23
      run8(8'h5A, 8'h23, 4'b0010); chk("R2", "A+B", int'(g8), 8'h7D);
      run8(8'h5A, 8'h23, 4'b0101); chk("R2", "A-B", int'(g8), 8'h37);
      run8(8'h5A, 8'h23, 4'b0110); chk("R2", "A-1", int'(g8), 8'h59);
      run8(8'h5A, 8'h23, 4'b0001); chk("R2", "A+1", int'(g8), 8'h5B);
      run8(8'h5A, 8'h23, 4'b0000); chk("R2", "pass A", int'(g8), 8'h5A);
      // R4 signed boundary: 0x7F + 1 overflows, no carry
      run8(8'h7F, 8'h01, 4'b0010);
      chk("R4", "7F+1 v", int'(v8), 1); chk("R4", "7F+1 c", int'(c8), 0);
      // R3: carry-in has no effect in logic mode
      for (int s = 8; s < 16; s += 2) begin
         run8(8'hC6, 8'h5B, s);  gsave = g8;
         run8(8'hC6, 8'h5B, s + 1);
         chk("R3", "cin ignored", int'(g8), int'(gsave));
      end
      // exhaustive 4-bit sweep
      for (int s = 0; s < 16; s++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               run4(a, b, s);
      // 8-bit edge sweep
      for (int s = 0; s < 16; s++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               run8(edges[i], edges[j], s);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule